// File: doc/BRIEF.md
# Rounding Arithmetic Right Shifter

This block divides a signed two's-complement word by a power of two. It shifts the word right, copying the sign bit into the vacated upper positions, and rounds the quotient to the nearest integer, with exact halves going toward positive infinity. The whole path is combinational: a result appears in the same cycle that its operands are presented.

Rounding needs no general adder. The bit at the top of the discarded field is the round-up decision, and it enters an increment network as the carry-in. Each bit of the shifted word acts as the propagate term for its own position. There are no generate terms, because the value added is only ever 0 or 1. The carry into each position is the round bit ANDed with every shifted bit below it. All of these carries are formed side by side, so no carry ripples from bit to bit.

Top module: `rshr_round_top`

## Requirements
- R1: Every upper bit position vacated by the shift holds a copy of the input sign bit (bit WIDTH-1 of `din`).
- R2: The result is the sign-extended shifted word plus 1 exactly when input bit `shamt-1` is 1, and the shifted word unchanged when that bit is 0.
- R3: A shift amount of 0 discards no bit and does not round, so `dout` equals `din`.
- R4: Any shift amount greater than WIDTH-1 behaves exactly like a shift amount of WIDTH-1.
- R5: The round-up increment wraps modulo 2^WIDTH: a shifted word of all ones plus a round-up gives all zeros, and the carry out of the top bit is dropped.
- R6: For every input and legal shift amount s, `dout` as a signed number equals floor(din / 2^s + 1/2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | WIDTH | Signed two's-complement dividend |
| shamt | input | $clog2(WIDTH)+1 | Shift distance (the power of two); values above WIDTH-1 are clamped |
| dout | output | WIDTH | Rounded, sign-extended quotient |

## Verification
The block holds no state, so a faulty internal signal shows up on `dout` for the same operands, without delay.
- A wrong round-bit selection moves the result by exactly one unit, and only when the discarded field's top bit differs from its neighbour. The vectors therefore put 0 and 1 in that position for the same shift.
- A broken carry term is seen only when a long run of ones sits in the low shifted bits. The cases that carry across most of the word, and the wrap to zero, are driven on purpose.
- The random sweep covers every shift amount, including the clamped ones.

// File: rtl/rshr_pkg.sv
package rshr_pkg;

  // Limits a requested shift distance to the largest meaningful one.
  function automatic int clamp_shift(input int req, input int width);
    return (req > width - 1) ? width - 1 : req;
  endfunction

endpackage

// File: rtl/rshr_shift_stage.sv
module rshr_shift_stage #(
  parameter int WIDTH = 16,
  localparam int SHW  = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SHW-1:0]   shamt,
  output logic [WIDTH-1:0] shifted,
  output logic             round_up
);

  localparam logic [SHW-1:0] MAX_SH = SHW'(WIDTH - 1);

  logic [SHW-1:0] amt_eff;

  always_comb begin
    amt_eff = SHW'(rshr_pkg::clamp_shift(int'(shamt), WIDTH));
  end

  // Sign-filling shift of the dividend.
  always_comb begin
    shifted = WIDTH'($signed(din) >>> amt_eff);
  end

  // Top bit of the discarded field; none exists when nothing is shifted.
  always_comb begin
    round_up = 1'b0;
    for (int k = 0; k < WIDTH; k++) begin
      if (amt_eff == SHW'(k + 1)) round_up = din[k];
    end
  end

  always_comb begin
    // R1
    sign_kept_chk: assert (shifted[WIDTH-1] == din[WIDTH-1]);
    // R3
    if (shamt == '0) begin
      zero_shift_chk: assert (shifted == din && !round_up);
    end
    // R4
    clamp_range_chk: assert (amt_eff <= MAX_SH);
  end

endmodule

// File: rtl/rshr_inc_chain.sv
module rshr_inc_chain #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] prop,
  input  logic             cin,
  output logic [WIDTH-1:0] sum
);

  logic [WIDTH-1:0] carry;

  assign carry[0] = cin;

  // Each carry looks straight back to the carry-in through the propagate bits.
  for (genvar i = 1; i < WIDTH; i++) begin : g_carry
    assign carry[i] = cin & (&prop[i-1:0]);
  end

  assign sum = prop ^ carry;

  always_comb begin
    // R2
    inc_value_chk: assert (sum == prop + {{(WIDTH-1){1'b0}}, cin});
    // R5
    if (cin && (&prop)) begin
      wrap_zero_chk: assert (sum == '0);
    end
    for (int i = 1; i < WIDTH; i++) begin
      // R2
      carry_prefix_chk: assert (!carry[i] || carry[i-1]);
    end
  end

endmodule

// File: rtl/rshr_round_top.sv
module rshr_round_top #(
  parameter int WIDTH = 16,
  localparam int SHW  = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SHW-1:0]   shamt,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] shifted;
  logic             round_up;

  rshr_shift_stage #(.WIDTH(WIDTH)) u_shift (
    .din      (din),
    .shamt    (shamt),
    .shifted  (shifted),
    .round_up (round_up)
  );

  rshr_inc_chain #(.WIDTH(WIDTH)) u_inc (
    .prop (shifted),
    .cin  (round_up),
    .sum  (dout)
  );

  always_comb begin
    // R3
    if (shamt == '0) begin
      pass_through_chk: assert (dout == din);
    end
    // R2
    if (!round_up) begin
      no_round_chk: assert (dout == shifted);
    end
  end

endmodule

// File: tb/test_rshr_round_top.sv
module test_rshr_round_top;

  localparam int WIDTH = 16;
  localparam int SHW   = $clog2(WIDTH) + 1;
  localparam int NVEC  = 17;

  // {din, shamt, expected}
  localparam logic [WIDTH+SHW+WIDTH-1:0] VEC [NVEC] = '{
    {16'h1234, 5'd0,  16'h1234},  // R3
    {16'h8000, 5'd0,  16'h8000},  // R3
    {16'h0007, 5'd1,  16'h0004},  // R2 round up
    {16'h0006, 5'd1,  16'h0003},  // R2 no round
    {16'hFFFD, 5'd1,  16'hFFFF},  // R6 -1.5 -> -1
    {16'h8000, 5'd4,  16'hF800},  // R1
    {16'h8008, 5'd4,  16'hF801},  // R1 with round
    {16'hFFFF, 5'd1,  16'h0000},  // R5
    {16'hFFFF, 5'd15, 16'h0000},  // R5
    {16'hC000, 5'd15, 16'h0000},  // R5
    {16'h8000, 5'd15, 16'hFFFF},  // R1
    {16'h4000, 5'd15, 16'h0001},  // R2
    {16'h7FFF, 5'd1,  16'h4000},  // R2 long carry
    {16'h4000, 5'd20, 16'h0001},  // R4
    {16'hC000, 5'd31, 16'h0000},  // R4
    {16'h00FF, 5'd8,  16'h0001},  // R2
    {16'h01FF, 5'd4,  16'h0020}   // R2
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [WIDTH-1:0] din   = '0;
  logic [SHW-1:0]   shamt = '0;
  logic [WIDTH-1:0] dout;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  rshr_round_top #(.WIDTH(WIDTH)) i_rshr_round_top (
    .din   (din),
    .shamt (shamt),
    .dout  (dout)
  );

  // Independent model: rounded quotient floor(x/2^s + 1/2) in wide signed arithmetic.
  function automatic logic [WIDTH-1:0] model(input logic [WIDTH-1:0] x, input int s);
    longint v;
    int     se;
    se = (s > WIDTH - 1) ? WIDTH - 1 : s;
    v  = longint'($signed(x));
    if (se == 0) return x;
    v = (v + (longint'(1) <<< (se - 1))) >>> se;
    return v[WIDTH-1:0];
  endfunction

  task automatic apply(input logic [WIDTH-1:0] x, input logic [SHW-1:0] s,
                       input logic [WIDTH-1:0] exp, input string req);
    @(posedge clk);
    din   = x;
    shamt = s;
    @(negedge clk);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s din=%h shamt=%0d actual=%h expected=%h", req, x, s, dout, exp);
    end
  endtask

  initial begin
    // Initial state: zero operands give zero (R3).
    @(negedge clk);
    checks++;
    if (dout !== '0) begin
      errors++;
      $display("FAIL R3 initial actual=%h expected=0000", dout);
    end

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][WIDTH+SHW+WIDTH-1 -: WIDTH], VEC[i][WIDTH+SHW-1 -: SHW],
            VEC[i][WIDTH-1:0], "R1/R2/R3/R4/R5 table");
    end

    // R6 sweep over every shift amount with random operands.
    for (int s = 0; s < (1 << SHW); s++) begin
      for (int n = 0; n < 40; n++) begin
        logic [WIDTH-1:0] x;
        x = WIDTH'($urandom);
        apply(x, SHW'(s), model(x, s), "R6 sweep");
      end
    end

    // R1 sign fill on extreme negative values, every legal shift.
    for (int s = 1; s < WIDTH; s++) begin
      apply(16'h8000, SHW'(s), model(16'h8000, s), "R1 sign fill");
    end

    // R4 clamp: every oversize amount matches the largest legal one.
    for (int s = WIDTH; s < (1 << SHW); s++) begin
      apply(16'h6ABC, SHW'(s), model(16'h6ABC, WIDTH - 1), "R4 clamp");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule